// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a read or write burst in a synchronous DRAM controller. A start strobe loads a starting column, a length code and an ordering choice. The block then presents one column per clock on `col_o`, with `col_vld_o` high, until the burst runs out, is stopped, or is replaced by a new start.

Fixed-length bursts of 1, 2, 4 or 8 words stay inside the aligned block of that size. The column can count upwards with wrap-around, or it can follow an XOR (interleaved) pattern. A page-length burst walks the whole column space and wraps from the top column to zero. It never ends by itself. A request the block cannot serve is dropped and flagged for one cycle.

Command decoding and data storage belong to the surrounding controller. All outputs come from registers loaded on the rising clock edge, so a request sampled at one edge shows its effect in the following cycle.

Top module: `burst_colgen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `col_vld_o`, `last_o` and `illegal_o` are 0 and `col_o` is 0.
- R2: Legal length codes on `len_code_i` are 0 (1 word), 1 (2 words), 2 (4 words), 3 (8 words) and 7 (page). A legal `start_i` makes `col_vld_o` 1 in the next cycle with `col_o` equal to `start_col_i`. That cycle is beat 0.
- R3: With `ilv_i`=0 and a fixed length N, beat k has low log2(N) bits equal to (start + k) mod N. The upper column bits equal those of the start column.
- R4: With `ilv_i`=1 and a fixed length N, beat k has low log2(N) bits equal to the start's low bits XOR k. The upper bits are unchanged.
- R5: `last_o` is 1 exactly on beat N-1 of a fixed-length burst. Without a new legal start, `col_vld_o` is 0 in the cycle that follows.
- R6: A page burst (code 7, `ilv_i`=0) adds one to the column each cycle modulo 2^COL_W. It continues without limit, and `last_o` stays 0 for its whole length.
- R7: A start with code 4, 5 or 6, or with code 7 and `ilv_i`=1, is illegal. It loads nothing, and `illegal_o` is 1 for the next cycle only. A burst already running continues as if no start had come.
- R8: `stop_i` high at an edge with no legal start ends the burst. `col_vld_o` is 0 from the next cycle.
- R9: A legal start while a burst is active replaces that burst at the same edge. It wins over `stop_i` and over the end of the old burst, and the next cycle shows beat 0 of the new burst.
- R10: `col_o` is 0 whenever `col_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start (or restart) strobe |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| stop_i | input | 1 | End the current burst |
| col_o | output | COL_W | Column of the current beat |
| col_vld_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |
| illegal_o | output | 1 | The previous start request was refused |

## Verification
The assertions assume that the inputs are known after reset. They also assume that `len_code_i` and `ilv_i` carry meaning only when `start_i` is high. Beyond that they accept any column, any mix of start and stop, and restarts on any beat. The stimulus therefore draws codes across all eight values, including the illegal ones. It lets stop and start coincide and restarts bursts at random beats, while directed cases cover wrap at the page top, block wrap and length-1 bursts.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

  // Length code values
  localparam logic [2:0] LEN_1    = 3'd0;
  localparam logic [2:0] LEN_2    = 3'd1;
  localparam logic [2:0] LEN_4    = 3'd2;
  localparam logic [2:0] LEN_8    = 3'd3;
  localparam logic [2:0] LEN_PAGE = 3'd7;

  // A request is serviceable for fixed lengths in either order,
  // and for page length only in counting order.
  function automatic logic code_ok(input logic [2:0] code, input logic ilv);
    return (code <= LEN_8) || ((code == LEN_PAGE) && !ilv);
  endfunction

endpackage

// File: rtl/burst_colgen_decode.sv
module burst_colgen_decode
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       code_i,
  input  logic             ilv_i,
  output logic             legal_o,
  output logic             full_o,
  output logic [COL_W-1:0] mask_o
);

  always_comb begin
    legal_o = code_ok(code_i, ilv_i);
    full_o  = (code_i == LEN_PAGE);
    unique case (code_i)
      LEN_1:   mask_o = COL_W'(0);
      LEN_2:   mask_o = COL_W'(1);
      LEN_4:   mask_o = COL_W'(3);
      LEN_8:   mask_o = COL_W'(7);
      default: mask_o = '1;
    endcase
  end

endmodule

// File: rtl/burst_colgen_seq.sv
module burst_colgen_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             reject_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic             full_i,
  output logic             act_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o,
  output logic             full_o,
  output logic             last_o,
  output logic             illegal_o
);

  logic             act_q, ilv_q, full_q, ill_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             last_w;

  // Final beat of a fixed burst: beat index equals length minus one
  assign last_w = act_q && !full_q && (beat_q == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
      ill_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else begin
      ill_q <= reject_i;
      if (load_i) begin
        act_q  <= 1'b1;
        base_q <= start_col_i;
        beat_q <= '0;
        mask_q <= mask_i;
        ilv_q  <= ilv_i;
        full_q <= full_i;
      end else if (stop_i || last_w) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        beat_q <= beat_q + COL_W'(1);
      end
    end
  end

  assign act_o     = act_q;
  assign base_o    = base_q;
  assign beat_o    = beat_q;
  assign mask_o    = mask_q;
  assign ilv_o     = ilv_q;
  assign full_o    = full_q;
  assign last_o    = last_w;
  assign illegal_o = ill_q;

  AST_LOAD_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (act_q && beat_q == '0)); // R2
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_w && !load_i) |=> !act_q); // R5
  AST_BEAT_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !full_q) |-> ((beat_q & ~mask_q) == '0)); // R5
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !load_i) |=> !act_q); // R8

endmodule

// File: rtl/burst_colgen_addr.sv
module burst_colgen_addr #(
  parameter int COL_W = 8
) (
  input  logic             act_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic             full_i,
  output logic [COL_W-1:0] col_o
);

  // Column of beat k: page bursts count over all bits; fixed bursts
  // change only the masked low bits, by adding or by XOR.
  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] base, input logic [COL_W-1:0] k,
    input logic [COL_W-1:0] m, input logic ilv, input logic full);
    logic [COL_W-1:0] low;
    if (full) return base + k;
    low = ilv ? (base ^ k) : (base + k);
    return (base & ~m) | (low & m);
  endfunction

  assign col_o = act_i ? beat_col(base_i, beat_i, mask_i, ilv_i, full_i) : '0;

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_vld_o,
  output logic             last_o,
  output logic             illegal_o
);

  logic             legal_w, req_full_w, load_w, reject_w;
  logic [COL_W-1:0] req_mask_w;
  logic             act_w, ilv_q_w, full_q_w;
  logic [COL_W-1:0] base_w, beat_w, mask_q_w;

  burst_colgen_decode #(.COL_W(COL_W)) u_decode (
    .code_i (len_code_i),
    .ilv_i  (ilv_i),
    .legal_o(legal_w),
    .full_o (req_full_w),
    .mask_o (req_mask_w)
  );

  assign load_w   = start_i && legal_w;
  assign reject_w = start_i && !legal_w;

  burst_colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_w),
    .reject_i   (reject_w),
    .stop_i     (stop_i),
    .start_col_i(start_col_i),
    .mask_i     (req_mask_w),
    .ilv_i      (ilv_i),
    .full_i     (req_full_w),
    .act_o      (act_w),
    .base_o     (base_w),
    .beat_o     (beat_w),
    .mask_o     (mask_q_w),
    .ilv_o      (ilv_q_w),
    .full_o     (full_q_w),
    .last_o     (last_o),
    .illegal_o  (illegal_o)
  );

  burst_colgen_addr #(.COL_W(COL_W)) u_addr (
    .act_i (act_w),
    .base_i(base_w),
    .beat_i(beat_w),
    .mask_i(mask_q_w),
    .ilv_i (ilv_q_w),
    .full_i(full_q_w),
    .col_o (col_o)
  );

  assign col_vld_o = act_w;

  AST_REPLACE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> (col_vld_o && col_o == $past(start_col_i))); // R9
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld_o && !full_q_w && $past(col_vld_o) && !$past(load_w))
      |-> ((col_o & ~mask_q_w) == ($past(col_o) & ~mask_q_w))); // R3
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld_o && full_q_w && $past(col_vld_o) && !$past(load_w))
      |-> (col_o == $past(col_o) + COL_W'(1))); // R6
  AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    reject_w |=> illegal_o); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !col_vld_o |-> (col_o == '0)); // R10

endmodule

// File: tb/tb_burst_colgen.sv
module tb_burst_colgen;

  localparam int COL_W = 8;
  localparam int CLK_P = 10;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             ilv_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             col_vld_o, last_o, illegal_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Reference state, kept in terms of the requirements
  bit m_act = 0, m_ilv = 0, m_ill = 0, m_restart = 0;
  int m_start = 0, m_code = 0, m_k = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_colgen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .col_vld_o(col_vld_o), .last_o(last_o), .illegal_o(illegal_o)
  );

  function automatic int burst_len(input int code);
    return (code == 7) ? PAGE : (1 << code);
  endfunction

  // Expected column of beat k, written with block arithmetic
  function automatic int want_col(input int s, input int k, input int code, input bit il);
    int n, blk, off;
    if (code == 7) return (s + k) % PAGE;
    n   = burst_len(code);
    blk = s - (s % n);
    off = il ? ((s % n) ^ (k % n)) : (((s % n) + k) % n);
    return blk + off;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Check the present cycle, drive the next request, advance the model
  task automatic step(input bit st, input int col, input int code, input bit il, input bit sp);
    bit    e_last, legal;
    string tag;
    e_last = m_act && (m_code != 7) && (m_k == burst_len(m_code) - 1);
    chk(m_act ? "R2 valid" : "R8 idle", int'(col_vld_o), int'(m_act));
    if (m_act) begin
      if (m_k == 0)        tag = m_restart ? "R9 replaced beat0" : "R2 beat0";
      else if (m_code == 7) tag = "R6 page column";
      else if (m_ilv)      tag = "R4 interleaved column";
      else                 tag = "R3 sequential column";
      chk(tag, int'(col_o), want_col(m_start, m_k, m_code, m_ilv));
    end else begin
      chk("R10 idle column", int'(col_o), 0);
    end
    chk((m_code == 7) ? "R6 last" : "R5 last", int'(last_o), int'(e_last));
    chk("R7 refuse flag", int'(illegal_o), int'(m_ill));

    start_i     = st;
    start_col_i = COL_W'(col);
    len_code_i  = 3'(code);
    ilv_i       = il;
    stop_i      = sp;

    legal = (code <= 3) || (code == 7 && !il);
    m_ill = st && !legal;
    if (st && legal) begin
      m_restart = m_act;
      m_act = 1; m_start = col; m_code = code; m_ilv = il; m_k = 0;
    end else if (sp || e_last) begin
      m_act = 0; m_restart = 0;
    end else if (m_act) begin
      m_k = (m_k + 1) % PAGE;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 vld in reset", int'(col_vld_o), 0);
    chk("R1 last in reset", int'(last_o), 0);
    chk("R1 flag in reset", int'(illegal_o), 0);
    chk("R1 col in reset", int'(col_o), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 vld after reset", int'(col_vld_o), 0);

    // Sequential 8-word burst that wraps inside its block (R3, R5)
    step(1, 'h25, 3, 0, 0); idle(9);
    // Interleaved 4-word burst (R4)
    step(1, 'h46, 2, 1, 0); idle(5);
    // Interleaved 8-word burst
    step(1, 'h9B, 3, 1, 0); idle(9);
    // Page burst across the top column, then stopped (R6, R8)
    step(1, 253, 7, 0, 0); idle(6); step(0, 0, 0, 0, 1); idle(2);
    // Restart mid-burst together with stop (R9)
    step(1, 10, 3, 0, 0); idle(3); step(1, 200, 1, 0, 1); idle(3);
    // Restart on the final beat of a burst (R9)
    step(1, 40, 1, 0, 0); idle(1); step(1, 60, 1, 1, 0); idle(3);
    // Illegal requests during a burst, which must continue (R7)
    step(1, 'h10, 2, 0, 0); idle(1); step(1, 'h99, 7, 1, 0);
    step(1, 'h55, 5, 0, 0); idle(3);
    // Single-word burst and stop while idle
    step(1, 77, 0, 1, 0); idle(1); step(0, 0, 0, 0, 1); idle(1);

    // Constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int r, c;
      bit st, sp, il;
      r  = int'($urandom % 100);
      st = (r < 14);
      sp = (int'($urandom % 100) < 4);
      il = $urandom % 2;
      c  = int'($urandom % 12);
      if (c > 3) c = (c < 9) ? 7 : (c - 5);
      step(st, int'($urandom % PAGE), c, il, sp);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule